// File: doc/BRIEF.md
# Integer ALU with Compare-Set Operations

This block is the purely combinational arithmetic and logic unit of a small 32-bit integer CPU core. It takes two operands and a 4-bit operation code. It returns a 32-bit result, together with a flag that goes high when the first operand is zero. The branch unit uses that flag for both the branch-if-zero and the branch-if-not-zero decisions. Choosing the operands, extending immediates and writing back the result all happen outside this block.

The supported operations are wrap-around add and subtract, bitwise and/or/xor, and three shifts: left, logical right and arithmetic right. A shift moves by only the low three bits of the second operand. There are also four compare operations that write a whole word holding 0 or 1. Internally, a decoder turns the operation code into a small struct of strobes. A datapath then forms every candidate result and combines the enabled one. A thin top module joins the two.

Top module: `alu_core`

## Requirements
- R1: Code 0 (add) gives (opA + opB) mod 2^32. No carry or overflow is reported, and the result simply wraps.
- R2: Code 1 (subtract) gives (opA - opB) mod 2^32, and it also wraps without any indication.
- R3: Codes 2, 3 and 4 give the bitwise AND, OR and XOR of opA and opB, in that order.
- R4: Code 5 (shift left) shifts opA left by opB[2:0] and fills with zeros. Bits opB[31:3] have no effect.
- R5: Code 6 (logical right shift) shifts opA right by opB[2:0] and fills the vacated top bits with zeros. Bits opB[31:3] have no effect.
- R6: Code 7 (arithmetic right shift) shifts opA right by opB[2:0] and fills the vacated top bits with copies of opA[31].
- R7: Code 8 (equal) gives 1 when opA equals opB and 0 otherwise. Code 9 (not equal) gives the inverse. Bits 31..1 of the result are zero.
- R8: Code 10 (less than) and code 11 (less or equal) compare opA with opB as two's-complement signed values. Each gives exactly 1 when true and 0 when false.
- R9: aZero is 1 exactly when opA is zero, whatever the operation code.
- R10: Codes 12 to 15 are unassigned, and each of them gives a result of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand; also the value that the zero test examines |
| opB | input | 32 | Second operand; its low 3 bits are the shift distance |
| opSel | input | 4 | Operation code (0 to 11 assigned, 12 to 15 give zero) |
| result | output | 32 | Result of the selected operation |
| aZero | output | 1 | High when opA is zero |

## Verification
The signed-compare corners are the hardest to hit from uniformly random operands. These include operands that straddle 0x80000000 and 0x7FFFFFFF, and operands that are exactly equal, where less-or-equal and less-than must disagree. Random 32-bit values almost never land on these cases. Shifts whose opB has high bits set but low bits chosen are equally unlikely. The stimulus therefore opens with directed vectors for these cases. It then draws operands from a mix of full-range values, sign-boundary constants and copies of opA, so that equality and the sign edge recur throughout the random phase.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_BITS = 4;

  typedef enum logic [OP_BITS-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_SLL = 4'd5,
    OP_SRL = 4'd6,
    OP_SRA = 4'd7,
    OP_SEQ = 4'd8,
    OP_SNE = 4'd9,
    OP_SLT = 4'd10,
    OP_SLE = 4'd11
  } aluOp_e;

  // Strobes from the decoder to the datapath; at most one result source is enabled.
  typedef struct packed {
    logic arithEn;
    logic subMode;
    logic andEn;
    logic orEn;
    logic xorEn;
    logic shlEn;
    logic shrEn;
    logic fillSign;
    logic eqEn;
    logic neEn;
    logic ltEn;
    logic leEn;
  } aluStrobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [OP_BITS-1:0] opSel,
  output aluStrobe_t         strobe
);

  always_comb begin
    strobe = '0;
    case (opSel)
      OP_ADD: strobe.arithEn = 1'b1;
      OP_SUB: begin
        strobe.arithEn = 1'b1;
        strobe.subMode = 1'b1;
      end
      OP_AND: strobe.andEn = 1'b1;
      OP_OR:  strobe.orEn  = 1'b1;
      OP_XOR: strobe.xorEn = 1'b1;
      OP_SLL: strobe.shlEn = 1'b1;
      OP_SRL: strobe.shrEn = 1'b1;
      OP_SRA: begin
        strobe.shrEn    = 1'b1;
        strobe.fillSign = 1'b1;
      end
      OP_SEQ: strobe.eqEn = 1'b1;
      OP_SNE: strobe.neEn = 1'b1;
      OP_SLT: strobe.ltEn = 1'b1;
      OP_SLE: strobe.leEn = 1'b1;
      default: strobe = '0;
    endcase
  end

  // Unassigned codes must leave every result source disabled.
  always_comb begin
    if (!$isunknown(opSel) && opSel > OP_SLE) begin
      AST_UNUSED_QUIET: assert (strobe == '0); // R10
    end
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int SHAMT_BITS = 3
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobe_t       strobe,
  output logic [WIDTH-1:0] result,
  output logic             aZero
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0]      bOperand;
  logic [WIDTH-1:0]      sumOut;
  logic [WIDTH-1:0]      andOut;
  logic [WIDTH-1:0]      orOut;
  logic [WIDTH-1:0]      xorOut;
  logic [WIDTH-1:0]      shlOut;
  logic [WIDTH-1:0]      shrOut;
  logic [SHAMT_BITS-1:0] shamt;
  logic                  isEqual;
  logic                  isLess;
  logic                  setBit;

  // Single adder shared by add and subtract (invert and carry-in for subtract).
  assign bOperand = strobe.subMode ? ~opB : opB;
  assign sumOut   = opA + bOperand + {{(WIDTH-1){1'b0}}, strobe.subMode};

  // Bitwise logic built lane by lane.
  for (genvar lane = 0; lane < WIDTH; lane++) begin : g_lane
    assign andOut[lane] = opA[lane] & opB[lane];
    assign orOut[lane]  = opA[lane] | opB[lane];
    assign xorOut[lane] = opA[lane] ^ opB[lane];
  end

  // Shifter: only the low bits of the second operand set the distance.
  assign shamt  = opB[SHAMT_BITS-1:0];
  assign shlOut = opA << shamt;
  assign shrOut = strobe.fillSign ? WIDTH'($signed(opA) >>> shamt) : (opA >> shamt);

  // Comparator, signed for ordering.
  assign isEqual = (opA == opB);
  assign isLess  = ($signed(opA) < $signed(opB));
  assign setBit  = (strobe.eqEn & isEqual) | (strobe.neEn & ~isEqual) |
                   (strobe.ltEn & isLess)  | (strobe.leEn & (isLess | isEqual));

  // Result combine: OR of gated sources.
  always_comb begin
    result = '0;
    if (strobe.arithEn) result = result | sumOut;
    if (strobe.andEn)   result = result | andOut;
    if (strobe.orEn)    result = result | orOut;
    if (strobe.xorEn)   result = result | xorOut;
    if (strobe.shlEn)   result = result | shlOut;
    if (strobe.shrEn)   result = result | shrOut;
    result[0] = result[0] | setBit;
  end

  assign aZero = ~|opA;

  // Checks on the combined datapath.
  always_comb begin
    if (!$isunknown({opA, opB, strobe})) begin
      AST_ONE_SOURCE: assert ($onehot0({strobe.arithEn, strobe.andEn, strobe.orEn, strobe.xorEn,
                                        strobe.shlEn, strobe.shrEn, strobe.eqEn, strobe.neEn,
                                        strobe.ltEn, strobe.leEn})); // R10
      if (strobe.arithEn && !strobe.subMode) begin
        AST_ADD_INVERTS: assert (result - opB == opA); // R1
      end
      if (strobe.arithEn && strobe.subMode) begin
        AST_SUB_INVERTS: assert (result + opB == opA); // R2
      end
      if (strobe.eqEn || strobe.neEn || strobe.ltEn || strobe.leEn) begin
        AST_SET_IS_BIT: assert (result[MSB:1] == '0); // R7
      end
      if (strobe.eqEn && opB == '0) begin
        AST_EQ_ZERO_FLAG: assert (result[0] == aZero); // R9
      end
      if (strobe.shlEn && shamt == '0) begin
        AST_SHL_NONE: assert (result == opA); // R4
      end
      if (strobe.shrEn && strobe.fillSign && shamt != '0) begin
        AST_SRA_SIGN: assert (result[MSB] == opA[MSB]); // R6
      end
      if (strobe.shrEn && !strobe.fillSign && shamt != '0) begin
        AST_SRL_ZERO_TOP: assert (result[MSB] == 1'b0); // R5
      end
    end
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int SHAMT_BITS = 3
) (
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic [OP_BITS-1:0] opSel,
  output logic [WIDTH-1:0]   result,
  output logic               aZero
);

  aluStrobe_t strobe;

  alu_ctrl i_ctrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  alu_datapath #(
    .WIDTH      (WIDTH),
    .SHAMT_BITS (SHAMT_BITS)
  ) i_datapath (
    .opA    (opA),
    .opB    (opB),
    .strobe (strobe),
    .result (result),
    .aZero  (aZero)
  );

  always_comb begin
    if (!$isunknown({opSel, result}) && opSel > OP_SLE) begin
      AST_UNUSED_ZERO: assert (result == '0); // R10
    end
  end

endmodule

// File: tb/test_alu_core.sv
module test_alu_core;

  logic        clk = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [3:0]  opSel = '0;
  logic [31:0] result;
  logic        aZero;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  alu_core i_alu_core (
    .opA    (opA),
    .opB    (opB),
    .opSel  (opSel),
    .result (result),
    .aZero  (aZero)
  );

  // Behavioural reference, written from the requirements.
  function automatic logic [31:0] refModel(input logic [31:0] a, input logic [31:0] b, input int op);
    longint unsigned wide;
    int              s;
    longint          sa;
    longint          sb;
    logic [31:0]     r;
    s  = int'(b % 8);
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      0: begin wide = longint'(a) + longint'(b); r = wide[31:0]; end
      1: begin wide = longint'(a) + 64'h1_0000_0000 - longint'(b); r = wide[31:0]; end
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: begin wide = longint'(a) * (64'd1 << s); r = wide[31:0]; end
      6: r = a / (32'd1 << s);
      7: begin
           r = a / (32'd1 << s);
           if (a[31]) r = r | ~(32'hFFFF_FFFF / (32'd1 << s));
         end
      8:  r = (a == b) ? 32'd1 : 32'd0;
      9:  r = (a != b) ? 32'd1 : 32'd0;
      10: r = (sa < sb) ? 32'd1 : 32'd0;
      11: r = (sa <= sb) ? 32'd1 : 32'd0;
      default: r = 32'd0;
    endcase
    return r;
  endfunction

  function automatic string reqOf(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2, 3, 4: return "R3";
      5: return "R4";
      6: return "R5";
      7: return "R6";
      8, 9: return "R7";
      10, 11: return "R8";
      default: return "R10";
    endcase
  endfunction

  // Drive just after a rising edge, compare on the following falling edge.
  task automatic apply(input logic [31:0] a, input logic [31:0] b, input int op);
    logic [31:0] expRes;
    logic        expZero;
    @(posedge clk);
    #1;
    opA   = a;
    opB   = b;
    opSel = 4'(op);
    @(negedge clk);
    expRes  = refModel(a, b, op);
    expZero = (a == 32'd0);
    compared++;
    if (result !== expRes) begin
      mismatched++;
      $display("FAIL %s op=%0d a=%h b=%h result actual=%h expected=%h",
               reqOf(op), op, a, b, result, expRes);
    end
    compared++;
    if (aZero !== expZero) begin
      mismatched++;
      $display("FAIL R9 op=%0d a=%h aZero actual=%b expected=%b", op, a, aZero, expZero);
    end
  endtask

  function automatic logic [31:0] pickOperand(input logic [31:0] other);
    case ($urandom_range(0, 5))
      0: return 32'h8000_0000;
      1: return 32'h7FFF_FFFF;
      2: return other;
      3: return 32'd0;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    // Idle state: all-zero inputs give zero result and aZero high (R1, R9).
    apply(32'd0, 32'd0, 0);
    // R1 wrap and no overflow effect.
    apply(32'h7FFF_FFFF, 32'd1, 0);
    apply(32'hFFFF_FFFF, 32'd1, 0);
    // R2 wrap.
    apply(32'd0, 32'd1, 1);
    apply(32'h8000_0000, 32'd1, 1);
    // R3 bitwise.
    apply(32'hF0F0_1234, 32'h0FF0_FF00, 2);
    apply(32'hF0F0_1234, 32'h0FF0_FF00, 3);
    apply(32'hF0F0_1234, 32'h0FF0_FF00, 4);
    // R4 high bits of opB ignored.
    apply(32'h8000_0001, 32'hFFFF_FFF9, 5);
    apply(32'h1234_5678, 32'hFFFF_FFF8, 5);
    // R5 and R6 on a negative operand, full distance 7 and high bits set.
    apply(32'h8000_0000, 32'h0000_0007, 6);
    apply(32'h8000_0000, 32'hABCD_EF0F, 7);
    apply(32'h4000_0000, 32'd7, 7);
    // R7 and R8 edges.
    apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 8);
    apply(32'hDEAD_BEEF, 32'hDEAD_BEEE, 9);
    apply(32'h8000_0000, 32'h7FFF_FFFF, 10);
    apply(32'h7FFF_FFFF, 32'h8000_0000, 10);
    apply(32'h0000_0005, 32'h0000_0005, 10);
    apply(32'h0000_0005, 32'h0000_0005, 11);
    apply(32'hFFFF_FFFF, 32'd0, 11);
    // R9 across operation codes, R10 unassigned codes.
    for (int op = 0; op < 16; op++) begin
      apply(32'd0, 32'h1357_9BDF, op);
      apply(32'h0000_0100, 32'h0000_0003, op);
    end
    // Mixed random phase, every code.
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a;
      logic [31:0] b;
      a = pickOperand(32'h0);
      b = pickOperand(a);
      apply(a, b, $urandom_range(0, 15));
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule